// File: doc/BRIEF.md
# Key-Guarded Sequence Table

This block holds a writable table of instruction sequences: 32 sequences, each four 32-bit words. A simple 32-bit register bus writes and reads the table. A write-protection state decides whether table writes are accepted. While the unit is locked, the table keeps its contents, but it can always be read.

The protection state changes in two steps. First, software writes a fixed magic value (0x5AF05AF0) to the key register at byte offset 0x18. Then its very next bus write goes to the lock control register at byte offset 0x1C and carries a command: 1 locks the table, 2 unlocks it. The key stays armed across idle cycles and reads. Any other write disarms it.

The table starts at byte offset 0x200. Sequence n begins at 0x200 + 16·n, and word w of that sequence sits at 0x200 + 16·n + 4·w.

Top module: `seqtable_guard`

## Requirements
- R1: After reset the unit is unlocked, every table word reads 0x00000000, and lock control reads 0x00000002.
- R2: A write of 0x5AF05AF0 to offset 0x18 arms the key for exactly the next bus write, whatever cycles pass before it. Reads do not disarm the key. Any other write disarms it, including a wrong key value or a write to another offset.
- R3: While the key is armed, a write of 0x1 to offset 0x1C locks the table and a write of 0x2 unlocks it.
- R4: A write to offset 0x1C while the key is not armed leaves the lock state unchanged.
- R5: After a valid key, a lock control value other than 0x1 or 0x2 leaves the lock state unchanged and still uses up the key.
- R6: While unlocked, a write to 0x200 + 16·n + 4·w (n < 32, w < 4) stores the data in word w of sequence n.
- R7: While locked, table writes are dropped and the stored contents stay unchanged.
- R8: A read appears on rd_data one clock after rd_en is sampled. Table reads return the stored word whether the unit is locked or unlocked.
- R9: Lock control reads back bit 0 set when locked and bit 1 set when unlocked, with all other bits zero. The key register and unmapped offsets read as zero. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 12 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 12 | Byte offset of the read |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |

## Verification
The bench builds the block with its default parameters: 32 sequences of four words and a 12-bit offset. At this size every one of the 128 table words can be written and read back in each protection state, using patterns computed from the word index.

Because the whole table is swept, a dropped write, an aliased index or a wrong base offset shows up at the exact word it affects. The small size also leaves room to try every ordering of key, lock command, stray write and read that the arming rule distinguishes.

// File: rtl/seqtable_guard_pkg.sv
`timescale 1ns/1ps
package seqtable_guard_pkg;

  localparam logic [31:0] KEY_MAGIC   = 32'h5AF0_5AF0;
  localparam int          KEY_OFS     = 'h018;
  localparam int          LOCKCTL_OFS = 'h01C;
  localparam int          TABLE_BASE  = 'h200;
  localparam logic [31:0] CMD_LOCK    = 32'h1;
  localparam logic [31:0] CMD_UNLOCK  = 32'h2;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_KEY   = 2'd1,
    ACC_LOCK  = 2'd2,
    ACC_TABLE = 2'd3
  } acc_kind_t;

endpackage

// File: rtl/sg_addr_decode.sv
`timescale 1ns/1ps
module sg_addr_decode
  import seqtable_guard_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int SEQ_COUNT     = 32,
  parameter int WORDS_PER_SEQ = 4,
  parameter int IDX_W         = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_t         kind,
  output logic [IDX_W-1:0]  idx
);
  localparam int SPAN_BYTES = SEQ_COUNT * WORDS_PER_SEQ * 4;

  // Byte offset with the low two bits dropped.
  function automatic logic [31:0] word_ofs(input logic [ADDR_W-1:0] a);
    logic [31:0] w;
    w = 32'(a);
    w[1:0] = 2'b00;
    return w;
  endfunction

  // Word index inside the table: (offset - base) / 4.
  function automatic logic [IDX_W-1:0] table_index(input logic [31:0] ofs);
    return IDX_W'((ofs - 32'(TABLE_BASE)) >> 2);
  endfunction

  function automatic acc_kind_t classify(input logic [31:0] ofs);
    if (ofs == 32'(KEY_OFS))
      return ACC_KEY;
    if (ofs == 32'(LOCKCTL_OFS))
      return ACC_LOCK;
    if (ofs >= 32'(TABLE_BASE) && ofs < 32'(TABLE_BASE + SPAN_BYTES))
      return ACC_TABLE;
    return ACC_NONE;
  endfunction

  logic [31:0] ofs;
  assign ofs  = word_ofs(addr);
  assign kind = classify(ofs);
  assign idx  = table_index(ofs);
endmodule

// File: rtl/sg_lock_ctrl.sv
`timescale 1ns/1ps
module sg_lock_ctrl
  import seqtable_guard_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  acc_kind_t         wr_kind,
  input  logic [DATA_W-1:0] wr_data,
  output logic              locked,
  output logic              armed
);
  logic key_hit;
  logic lock_cmd;
  logic set_ev;
  logic clr_ev;

  assign key_hit  = wr_en && (wr_kind == ACC_KEY) && (32'(wr_data) == KEY_MAGIC);
  assign lock_cmd = wr_en && (wr_kind == ACC_LOCK) && armed;
  assign set_ev   = lock_cmd && (32'(wr_data) == CMD_LOCK);
  assign clr_ev   = lock_cmd && (32'(wr_data) == CMD_UNLOCK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      locked <= 1'b0;
    end else begin
      if (wr_en)
        armed <= key_hit;
      if (set_ev)
        locked <= 1'b1;
      else if (clr_ev)
        locked <= 1'b0;
    end
  end

  // R4: a command on an unarmed key changes nothing
  a_r4_unkeyed_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == ACC_LOCK && !armed) |=> $stable(locked));

  // R5: an unknown command value changes nothing
  a_r5_bad_value_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == ACC_LOCK && 32'(wr_data) != CMD_LOCK &&
     32'(wr_data) != CMD_UNLOCK) |=> $stable(locked));

  // R2: arming only ever follows a write to the key offset
  a_r2_arm_from_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(wr_en && wr_kind == ACC_KEY));

  // R2: any write consumes the key unless it is a new key write
  a_r2_arm_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_en && wr_kind != ACC_KEY) |=> !armed);

  // R3: the lock state moves only on an armed lock command
  a_r3_change_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(locked) |-> $past(armed && wr_en && wr_kind == ACC_LOCK));
endmodule

// File: rtl/sg_table_mem.sv
`timescale 1ns/1ps
module sg_table_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              locked,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = mem[ridx];

  // R7: the write port never fires while protection is on
  a_r7_no_write_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !locked);
endmodule

// File: rtl/seqtable_guard.sv
`timescale 1ns/1ps
module seqtable_guard
  import seqtable_guard_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int DATA_W        = 32,
  parameter int SEQ_COUNT     = 32,
  parameter int WORDS_PER_SEQ = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = SEQ_COUNT * WORDS_PER_SEQ;
  localparam int IDX_W = $clog2(DEPTH);

  acc_kind_t         wr_kind;
  acc_kind_t         rd_kind;
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  rd_idx;
  logic              locked;
  logic              armed;
  logic              table_we;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] rd_next;

  sg_addr_decode #(.ADDR_W(ADDR_W), .SEQ_COUNT(SEQ_COUNT),
                   .WORDS_PER_SEQ(WORDS_PER_SEQ), .IDX_W(IDX_W))
    u_wdec (.addr(wr_addr), .kind(wr_kind), .idx(wr_idx));

  sg_addr_decode #(.ADDR_W(ADDR_W), .SEQ_COUNT(SEQ_COUNT),
                   .WORDS_PER_SEQ(WORDS_PER_SEQ), .IDX_W(IDX_W))
    u_rdec (.addr(rd_addr), .kind(rd_kind), .idx(rd_idx));

  sg_lock_ctrl #(.DATA_W(DATA_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_data(wr_data), .locked(locked), .armed(armed));

  assign table_we = wr_en && (wr_kind == ACC_TABLE) && !locked;

  sg_table_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .locked(locked), .we(table_we),
    .widx(wr_idx), .wdata(wr_data), .ridx(rd_idx), .rdata(mem_rdata));

  always_comb begin
    rd_next = '0;
    case (rd_kind)
      ACC_TABLE: rd_next = mem_rdata;
      ACC_LOCK:  rd_next = DATA_W'({!locked, locked});
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= rd_next;
  end

  // R9: lock readback always has exactly one state bit set
  a_r9_lock_readback_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_kind == ACC_LOCK) |=> ($countones(rd_data) == 1));

  // R8: output data only moves after a read request
  a_r8_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/seqtable_guard_bench.sv
`timescale 1ns/1ps
module seqtable_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seqtable_guard u_seqtable_guard (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  localparam logic [31:0] KEY = 32'h5AF05AF0;

  function automatic logic [11:0] word_addr(input int s, input int w);
    return 12'('h200 + 16 * s + 4 * w);
  endfunction

  function automatic logic [31:0] pat(input int i, input logic [31:0] salt);
    return (32'(i) * 32'h0100_0193) ^ salt ^ (32'(i) << 20);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic chk_lock(input string req, input logic [31:0] exp);
    logic [31:0] v;
    rd(12'h01C, v);
    chk(req, v, exp);
  endtask

  task automatic fill(input logic [31:0] salt);
    for (int s = 0; s < 32; s++)
      for (int w = 0; w < 4; w++)
        wr(word_addr(s, w), pat(s * 4 + w, salt));
  endtask

  task automatic sweep(input string req, input logic [31:0] salt, input bit zero);
    logic [31:0] v;
    for (int s = 0; s < 32; s++)
      for (int w = 0; w < 4; w++) begin
        rd(word_addr(s, w), v);
        chk(req, v, zero ? 32'h0 : pat(s * 4 + w, salt));
      end
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk_lock("R1 lock readback after reset", 32'h2);
    sweep("R1 table clear after reset", 32'h0, 1'b1);

    // R6 fill while unlocked, sweep back
    fill(32'hA5C3_0F1E);
    sweep("R6 write while unlocked", 32'hA5C3_0F1E, 1'b0);

    // R9 low address bits ignored
    rd(word_addr(5, 2) | 12'h3, v);
    chk("R9 byte offset ignored on read", v, pat(22, 32'hA5C3_0F1E));
    wr(word_addr(9, 1) | 12'h2, 32'h1234_5678);
    rd(word_addr(9, 1), v);
    chk("R9 byte offset ignored on write", v, 32'h1234_5678);
    wr(word_addr(9, 1), pat(37, 32'hA5C3_0F1E));

    // R9 key and unmapped offsets read zero
    rd(12'h018, v); chk("R9 key register reads zero", v, 32'h0);
    rd(12'h400, v); chk("R9 unmapped above table reads zero", v, 32'h0);
    rd(12'h020, v); chk("R9 unmapped low offset reads zero", v, 32'h0);

    // R3 lock with key
    wr(12'h018, KEY); wr(12'h01C, 32'h1);
    chk_lock("R3 keyed lock", 32'h1);

    // R7 writes dropped, R8 reads still allowed
    fill(32'h3C96_7E01);
    sweep("R7 R8 locked table unchanged", 32'hA5C3_0F1E, 1'b0);

    // R4 unkeyed unlock ignored
    wr(12'h01C, 32'h2);
    chk_lock("R4 unkeyed unlock ignored", 32'h1);

    // R2 intervening write disarms
    wr(12'h018, KEY); wr(word_addr(0, 0), 32'hDEAD_BEEF); wr(12'h01C, 32'h2);
    chk_lock("R2 stray write disarms key", 32'h1);
    rd(word_addr(0, 0), v);
    chk("R7 stray write while locked dropped", v, pat(0, 32'hA5C3_0F1E));

    // R2 reads and idle cycles keep key armed
    wr(12'h018, KEY);
    rd(word_addr(3, 3), v);
    repeat (4) @(posedge clk);
    #1 wr(12'h01C, 32'h2);
    chk_lock("R2 key survives reads and idle", 32'h2);

    // R2 wrong key value
    wr(12'h018, KEY ^ 32'h1); wr(12'h01C, 32'h1);
    chk_lock("R2 wrong key value ignored", 32'h2);

    // R2 key write to wrong offset
    wr(12'h01C, KEY); wr(12'h01C, 32'h1);
    chk_lock("R2 key at lock offset ignored", 32'h2);

    // R2 repeated key re-arms
    wr(12'h018, KEY); wr(12'h018, KEY); wr(12'h01C, 32'h1);
    chk_lock("R2 second key re-arms", 32'h1);
    wr(12'h018, KEY); wr(12'h01C, 32'h2);
    chk_lock("R3 keyed unlock", 32'h2);

    // R5 bad values after key
    wr(12'h018, KEY); wr(12'h01C, 32'h3);
    chk_lock("R5 value 3 ignored", 32'h2);
    wr(12'h01C, 32'h1);
    chk_lock("R5 bad value consumed key", 32'h2);
    wr(12'h018, KEY); wr(12'h01C, 32'h0);
    chk_lock("R5 value 0 ignored", 32'h2);
    wr(12'h018, KEY); wr(12'h01C, 32'h0000_0101);
    chk_lock("R5 upper bits make value invalid", 32'h2);

    // R5 while locked
    wr(12'h018, KEY); wr(12'h01C, 32'h1);
    wr(12'h018, KEY); wr(12'h01C, 32'h6);
    chk_lock("R5 bad value while locked ignored", 32'h1);
    wr(12'h018, KEY); wr(12'h01C, 32'h2);

    // R6 refill after unlock
    fill(32'h0BAD_F00D);
    sweep("R6 write after unlock", 32'h0BAD_F00D, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule